// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Shift Port

This block is an 8-bit synchronous serial port. It can run as clock master, where it drives its own shift clock, or as clock slave, where an external master supplies the clock. A host sets the configuration through a small register bus, loads the byte to send, and starts a transfer with a GO write that raises `busy`. The port then exchanges exactly eight bits, most significant bit first. It drops `busy` on its own, and the received byte replaces the sent one in the same shift register.

The configuration fields are independent of each other. They select the role (which clock the port uses), whether the data output drives the pin or releases it, the idle level of the clock, and the clock phase. In the phase field, 0 means sample on the rising edge and 1 means sample on the falling edge. In slave mode the external clock and serial input pass through a two-stage synchronizer followed by edge detection. Everything then runs on the system clock.

The host bus is a plain single-cycle register port with no back-pressure. Every write is taken in the cycle it is presented. A write is either applied at once or, when the port is locked, dropped with no record. Reads are combinational.

Top module: `dual_role_shift_port`

Register map on `host_addr`:
- 0 is CTRL (read/write). Bit 0 is `en`, bit 1 is `master`, bit 2 is `so_drive`, bit 3 is `idle_hi` and bit 4 is `alt_phase`.
- 1 is GO/STATUS. Writing 1 to bit 0 starts a transfer. A read returns `busy` in bit 0.
- 2 is DATA: the shift register.
- 3 reads as zero.

## Requirements
- R1: A transfer moves exactly 8 bits. `busy` falls within a few system cycles after the eighth sample edge. In master mode exactly eight clock pulses appear on `sk_out`, after which the clock stops at its idle level.
- R2: While CTRL bit 0 (`en`) is 0, `so_oe` and `sk_oe` are 0 and a GO write leaves `busy` at 0.
- R3: With `en` set, CTRL bit 1 = 1 gives master role (`sk_oe` = 1) and 0 gives slave role (`sk_oe` = 0, clock taken from `sk_in`). CTRL bit 2 = 1 drives `so_oe` = 1, and 0 leaves the data output released. All four combinations transfer correctly.
- R4: In master mode, writing 1 to bit 0 at address 1 sets `busy` in the next cycle. The first clock edge appears DIV_HALF system cycles after the write edge, and every half period lasts DIV_HALF cycles.
- R5: In slave mode, `sk_in` edges that arrive while `busy` is 0 leave DATA and `busy` unchanged.
- R6: With CTRL bit 4 = 0 (normal phase), `si_in` is sampled on the rising clock edge and `so_out` changes only on the falling edge.
- R7: With CTRL bit 4 = 1 (alternate phase), `si_in` is sampled on the falling edge and `so_out` changes only on the rising edge.
- R8: CTRL bit 3 sets the clock idle level (1 = high) independently of phase. `sk_out` sits at that level whenever no master clock is running.
- R9: After reset, CTRL reads 0 (normal phase, port disabled), `busy` is 0, and `so_oe` and `sk_oe` are 0.
- R10: Data is shifted MSB first. From the cycle after the GO write, `so_out` shows bit 7 of DATA. Received bits enter at bit 0, and after the transfer DATA reads the received byte.
- R11: Writes to CTRL, DATA or GO are ignored while `busy` is 1 or the master clock is still finishing its last pulse.
- R12: In slave mode, transfers work for any `sk_in` whose high and low levels each last at least 4 system cycles. A clock edge seen before the first sample edge does not disturb the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data (combinational) |
| busy | output | 1 | Transfer in progress |
| so_out | output | 1 | Serial data output value |
| so_oe | output | 1 | Serial data output enable |
| si_in | input | 1 | Serial data input |
| sk_out | output | 1 | Shift clock value in master mode |
| sk_oe | output | 1 | Shift clock output enable |
| sk_in | input | 1 | External shift clock in slave mode |

## Verification
Two things can fall in the same system cycle: a host DATA write and the shift engine's final sample edge, which both load the shift register and clears `busy`. To provoke this, the bench runs a master transfer and presents a DATA write in every cycle for which it saw `busy` high at the preceding falling clock edge. That includes the completion cycle itself. The result is judged by reading DATA once `busy` is low: it must equal the byte the bench slave sent, so every colliding write must have been dropped. A later write must still be accepted. Random role, phase, idle-level and slave-clock-rate mixes check the bit order and edge roles against bench models.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_GO   = 2'd1,
    REG_DATA = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  // packed MSB first: alt_phase is bit 4, en is bit 0
  typedef struct packed {
    logic alt_phase;
    logic idle_hi;
    logic so_drive;
    logic master;
    logic en;
  } port_cfg_t;

  localparam int CFG_W = $bits(port_cfg_t);
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else        st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sps_regs.sv
module sps_regs
  import sps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              clk_active,
  input  logic [DATA_W-1:0] shift_q,
  output port_cfg_t         cfg,
  output logic              go,
  output logic              load,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e sel;
  logic     lock;

  assign sel  = reg_sel_e'(addr);
  assign lock = busy | clk_active;
  assign go   = wr && (sel == REG_GO) && wdata[0] && cfg.en && !lock;
  assign load = wr && (sel == REG_DATA) && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (wr && (sel == REG_CTRL) && !lock) cfg <= port_cfg_t'(wdata[CFG_W-1:0]);
  end

  always_comb begin
    unique case (sel)
      REG_CTRL: rdata = {{(DATA_W-CFG_W){1'b0}}, cfg};
      REG_GO:   rdata = {{(DATA_W-1){1'b0}}, busy};
      REG_DATA: rdata = shift_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/sps_clkgen.sv
module sps_clkgen #(
  parameter int DIV_HALF = 4,
  parameter int PULSES   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic idle_hi,
  output logic lvl,
  output logic rise,
  output logic fall,
  output logic active
);
  localparam int CW      = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;
  localparam int TOGGLES = 2 * PULSES;
  localparam int TW      = $clog2(TOGGLES);

  logic [CW-1:0] cnt;
  logic [TW-1:0] tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl    <= 1'b0;
      rise   <= 1'b0;
      fall   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
      tog    <= '0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (!active) begin
        lvl <= idle_hi;
        if (start) begin
          active <= 1'b1;
          cnt    <= CW'(DIV_HALF - 1);
          tog    <= '0;
        end
      end else if (cnt == '0) begin
        lvl  <= ~lvl;
        rise <= ~lvl;
        fall <= lvl;
        cnt  <= CW'(DIV_HALF - 1);
        tog  <= tog + 1'b1;
        if (tog == TW'(TOGGLES - 1)) active <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sps_engine.sv
module sps_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              samp,
  input  logic              chg,
  input  logic              si,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic              busy,
  output logic [DATA_W-1:0] shift_q,
  output logic              so
);
  localparam int CW = $clog2(DATA_W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shift_q <= '0;
      so      <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      busy <= 1'b1;
      so   <= shift_q[DATA_W-1];
      cnt  <= '0;
    end else if (busy) begin
      if (samp) begin
        shift_q <= {shift_q[DATA_W-2:0], si};
        cnt     <= cnt + 1'b1;
        if (cnt == CW'(DATA_W - 1)) busy <= 1'b0;
      end else if (chg && (cnt != '0)) begin
        so <= shift_q[DATA_W-1];
      end
    end else if (load) begin
      shift_q <= load_val;
    end
  end
endmodule

// File: rtl/dual_role_shift_port.sv
module dual_role_shift_port
  import sps_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              busy,
  output logic              so_out,
  output logic              so_oe,
  input  logic              si_in,
  output logic              sk_out,
  output logic              sk_oe,
  input  logic              sk_in
);
  port_cfg_t         cfg;
  logic              go, load;
  logic [DATA_W-1:0] shift_q;
  logic              mclk_active, m_rise, m_fall;
  logic [1:0]        sync_q;
  logic              sk_prev, s_rise, s_fall;
  logic              edge_rise, edge_fall, samp, chg;

  sps_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .busy(busy), .clk_active(mclk_active), .shift_q(shift_q),
    .cfg(cfg), .go(go), .load(load), .rdata(host_rdata)
  );

  sps_clkgen #(.DIV_HALF(DIV_HALF), .PULSES(DATA_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(go && cfg.master), .idle_hi(cfg.idle_hi),
    .lvl(sk_out), .rise(m_rise), .fall(m_fall), .active(mclk_active)
  );

  sps_sync #(.W(2), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sk_in, si_in}), .q(sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_prev <= 1'b0;
    else        sk_prev <= sync_q[1];
  end

  assign s_rise    = sync_q[1] & ~sk_prev;
  assign s_fall    = ~sync_q[1] & sk_prev;
  assign edge_rise = cfg.master ? m_rise : s_rise;
  assign edge_fall = cfg.master ? m_fall : s_fall;
  assign samp      = cfg.alt_phase ? edge_fall : edge_rise;
  assign chg       = cfg.alt_phase ? edge_rise : edge_fall;

  sps_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(go), .samp(samp), .chg(chg), .si(sync_q[0]),
    .load(load), .load_val(host_wdata), .busy(busy), .shift_q(shift_q), .so(so_out)
  );

  assign so_oe = cfg.en & cfg.so_drive;
  assign sk_oe = cfg.en & cfg.master;
endmodule

// File: rtl/sps_checker.sv
module sps_checker
  import sps_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic              go_bit,
  input logic              busy,
  input logic              so_out,
  input logic              sk_out,
  input port_cfg_t         cfg,
  input logic              mclk_active,
  input logic              samp,
  input logic              chg,
  input logic              start
);
  logic [3:0] n_samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             n_samp <= '0;
    else if (start)         n_samp <= '0;
    else if (busy && samp)  n_samp <= n_samp + 1'b1;
  end

  AST_EIGHT_BITS_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (n_samp == 4'd8)); // R1
  AST_SAMPLE_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    n_samp <= 4'd8); // R1
  AST_GO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_wr && (host_addr == 2'd1) && go_bit && cfg.en)); // R2
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy || mclk_active) |-> $stable(cfg)); // R11
  AST_SO_ON_CHANGE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(chg) && !$past(start)) |-> $stable(so_out)); // R6
  AST_SK_IDLE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclk_active && !$past(mclk_active) && $stable(cfg.idle_hi)) |-> (sk_out == cfg.idle_hi)); // R8
endmodule

bind dual_role_shift_port sps_checker u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .go_bit(host_wdata[0]), .busy(busy), .so_out(so_out), .sk_out(sk_out),
  .cfg(cfg), .mclk_active(mclk_active), .samp(samp), .chg(chg), .start(go)
);

// File: tb/dual_role_shift_port_test.sv
module dual_role_shift_port_test;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       busy, so_out, so_oe, sk_out, sk_oe;
  logic       si_in = 1'b0;
  logic       sk_in = 1'b0;
  int         errors = 0;
  int         checks = 0;

  always #4 clk = ~clk;

  dual_role_shift_port #(.DIV_HALF(D)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .so_out(so_out), .so_oe(so_oe), .si_in(si_in), .sk_out(sk_out),
    .sk_oe(sk_oe), .sk_in(sk_in)
  );

  function automatic logic [7:0] ctrl_word(bit en, bit m, bit drv, bit idle, bit alt);
    return {3'b000, alt, idle, drv, m, en};
  endfunction

  function automatic bit is_sample_edge(bit new_lvl, bit alt);
    return alt ? !new_lvl : new_lvl;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic run_master(bit drv, bit idle, bit alt, logic [7:0] tx, logic [7:0] stx, bit hammer);
    logic [7:0] brx = 8'd0;
    logic [7:0] v;
    int n = 0, rises = 0, first = -1;
    logic prev;
    wr(2'd0, ctrl_word(1, 1, drv, idle, alt));
    wr(2'd2, tx);
    si_in = stx[7];
    wr(2'd1, 8'd1);
    chk(busy == 1'b1, "R4 busy after GO", busy, 1);
    chk(so_out == tx[7], "R10 first bit on so", so_out, tx[7]);
    chk({sk_oe, so_oe} == {1'b1, drv}, "R3 master oe decode", {sk_oe, so_oe}, {1'b1, drv});
    prev = sk_out;
    for (int k = 1; k <= 20 * D; k++) begin
      if (hammer && busy) begin
        host_wr = 1'b1; host_addr = 2'd2; host_wdata = 8'hE7 ^ 8'(k);
      end else host_wr = 1'b0;
      @(negedge clk);
      if (sk_out != prev) begin
        if (first < 0) first = k;
        if (sk_out) rises++;
        if (is_sample_edge(sk_out, alt)) begin
          brx = {brx[6:0], so_out}; n++;
        end else if (n > 0 && n < 8) si_in = stx[7-n];
        prev = sk_out;
      end
    end
    host_wr = 1'b0;
    chk(first == D, "R4 first edge delay", first, D);
    chk(rises == 8, "R1 master pulse count", rises, 8);
    chk(busy == 1'b0, "R1 busy cleared", busy, 0);
    chk(sk_out == idle, "R8 clock parked at idle", sk_out, idle);
    chk(brx == tx, alt ? "R7 slave saw master bits" : "R6 slave saw master bits", brx, tx);
    rd(2'd2, v);
    chk(v == stx, hammer ? "R11 colliding DATA writes dropped" : "R10 received byte", v, stx);
    if (hammer) begin
      wr(2'd2, 8'h5A);
      rd(2'd2, v);
      chk(v == 8'h5A, "R11 DATA write accepted when idle", v, 8'h5A);
    end
  endtask

  task automatic run_slave(bit drv, bit idle, bit alt, logic [7:0] tx, logic [7:0] mtx, int half);
    logic [7:0] brx = 8'd0;
    logic [7:0] v;
    int n = 0;
    bit nl;
    sk_in = idle;
    si_in = mtx[7];
    wr(2'd0, ctrl_word(1, 0, drv, idle, alt));
    repeat (4) @(negedge clk);
    wr(2'd2, tx);
    wr(2'd1, 8'd1);
    chk(so_out == tx[7], "R10 slave first bit", so_out, tx[7]);
    chk({sk_oe, so_oe} == {1'b0, drv}, "R3 slave oe decode", {sk_oe, so_oe}, {1'b0, drv});
    repeat (3) @(negedge clk);
    for (int e = 0; e < 16; e++) begin
      repeat (half) @(negedge clk);
      nl = !sk_in;
      if (is_sample_edge(nl, alt)) begin
        brx = {brx[6:0], so_out}; n++;
      end else if (n > 0 && n < 8) si_in = mtx[7-n];
      sk_in = nl;
    end
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R1 slave busy cleared", busy, 0);
    chk(brx == tx, alt ? "R7 R12 master saw slave bits" : "R6 R12 master saw slave bits", brx, tx);
    rd(2'd2, v);
    chk(v == mtx, "R10 R12 slave received byte", v, mtx);
  endtask

  initial begin
    #(8 * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    rd(2'd0, v);
    chk(v == 8'h00, "R9 CTRL after reset", v, 0);
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    chk({so_oe, sk_oe} == 2'b00, "R9 oe after reset", {so_oe, sk_oe}, 0);

    // R2 disabled port
    wr(2'd0, ctrl_word(0, 1, 1, 0, 0));
    chk({so_oe, sk_oe} == 2'b00, "R2 oe while disabled", {so_oe, sk_oe}, 0);
    wr(2'd1, 8'd1);
    begin
      bit moved = 0;
      for (int k = 0; k < 3 * D; k++) begin
        @(negedge clk);
        if (sk_out != 1'b0) moved = 1;
      end
      chk(busy == 1'b0, "R2 GO ignored while disabled", busy, 0);
      chk(moved == 0, "R2 no clock while disabled", moved, 0);
    end

    // R5 edges without busy ignored
    wr(2'd0, ctrl_word(1, 0, 1, 0, 0));
    wr(2'd2, 8'h3C);
    for (int e = 0; e < 16; e++) begin
      repeat (5) @(negedge clk);
      si_in = 1'($urandom);
      sk_in = !sk_in;
    end
    repeat (6) @(negedge clk);
    rd(2'd2, v);
    chk(v == 8'h3C, "R5 idle slave edges ignored", v, 8'h3C);
    chk(busy == 1'b0, "R5 busy stays low", busy, 0);

    // R11 CTRL and GO locked during transfer
    wr(2'd0, ctrl_word(1, 1, 1, 1, 0));
    si_in = 1'b0;
    wr(2'd1, 8'd1);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd1);
    rd(2'd0, v);
    chk(v == ctrl_word(1, 1, 1, 1, 0), "R11 CTRL write ignored while busy", v, ctrl_word(1, 1, 1, 1, 0));
    repeat (20 * D) @(negedge clk);
    chk(busy == 1'b0 && sk_out == 1'b1, "R8 idle-high park", {busy, sk_out}, 1);

    // directed corners: every role/output/phase/idle mix
    run_master(1, 0, 0, 8'hA5, 8'h3C, 0);
    run_master(0, 1, 1, 8'h81, 8'h7E, 0);
    run_master(1, 1, 0, 8'h01, 8'hFF, 1);
    run_slave(1, 1, 0, 8'hC3, 8'h96, 4);
    run_slave(0, 0, 1, 8'h80, 8'h01, 4);

    // constrained random
    for (int i = 0; i < 10; i++) begin
      run_master(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 0);
      run_slave(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
                4 + int'($urandom % 6));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule